// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block sits behind the analog front end of a 100 Mb/s twisted-pair receiver. Each cycle of the recovered 125 MHz bit clock it takes one three-level line symbol, already sliced into a 2-bit code. It undoes the whole transmit coding chain: the three-level transition code becomes a transition bit stream, which becomes a plain bit stream. That stream is descrambled against a locally regenerated 11-bit key sequence, split into aligned 5-bit code groups, and decoded into 4-bit nibbles for the MAC.

The descrambler is self-synchronising during idle. While it is unlocked it loads its shift register from the inverted line bits, because idle is all ones before scrambling. It declares lock after a long run of bits that agree with its own prediction. Code-group boundaries come from the start-of-stream pair. Nibbles are handed out with a one-cycle strobe, a frame-level valid flag and a per-nibble error flag. The end-of-stream pair closes the frame.

Top module: `fx_rx_decoder`

## Requirements
- R1: Symbol codes are 2'b00 zero, 2'b01 positive and 2'b11 negative; 2'b10 is taken as zero. A change of level between consecutive symbols is a transition bit of 1, and a plain bit is the XOR of two consecutive transition bits.
- R2: The key bit k[n] equals k[n-11] XOR k[n-9], and the descrambled bit is the plain line bit XOR k[n]; once locked, the key register runs free.
- R3: After reset `locked_o` is low. It rises only after 60 consecutive bits whose inverted value matches the key predicted from the 11 bits before them.
- R4: While locked and outside a frame, 4 consecutive descrambled zeros clear `locked_o`; this never happens inside a frame.
- R5: A frame starts only while locked, when the last 10 descrambled bits equal 1100010001 in arrival order. While unlocked no strobe is produced.
- R6: Each 5-bit group after the start pair (first-received bit as MSB) produces one `nib_stb_o` pulse. Data groups map as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. `rx_dv_o` rises with the first strobe.
- R7: The group 01101 ends the frame without a strobe and drops `rx_dv_o`. The next group must be 00111; otherwise one strobe with `rx_er_o` high, `rx_dv_o` low and nibble 0 follows.
- R8: Any other non-data group inside a frame gives a strobe with `rx_dv_o` and `rx_er_o` high and nibble 0, and the frame continues.
- R9: The idle group 11111 inside a frame gives an error strobe (valid high, nibble 0) and ends the frame; `rx_dv_o` is low from the next cycle.
- R10: Consecutive strobes are at least 5 cycles apart.
- R11: While reset is held and right after it, `locked_o`, `rx_dv_o`, `rx_er_o` and `nib_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 2 | Sliced three-level line symbol |
| locked_o | output | 1 | Descrambler lock |
| rx_dv_o | output | 1 | Frame valid toward the MAC |
| rx_er_o | output | 1 | Error flag, qualified by the strobe |
| nib_stb_o | output | 1 | One-cycle pulse per decoded nibble |
| nib_o | output | 4 | Decoded nibble |

## Verification
A wrong key register or transition stage shows up as garbled or missing nibbles on the very first frame after lock, because every data bit passes through both. A wrong lock counter moves the rising edge of `locked_o`, and that edge is checked against a window a few dozen cycles wide after reset. A misaligned group counter or a wrong frame state makes the strobe sequence disagree with the sent sequence within one or two code groups. The bench sweeps all 32 group values inside one frame, uses both zero-level codes, and forces a loss and regain of lock.

// File: rtl/fx_rx_pkg.sv
package fx_rx_pkg;

  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * GRP_W;

  localparam logic [GRP_W-1:0] GRP_END1 = 5'b01101;
  localparam logic [GRP_W-1:0] GRP_END2 = 5'b00111;
  localparam logic [GRP_W-1:0] GRP_IDLE = 5'b11111;
  localparam logic [WIN_W-1:0] START_PAT = 10'b1100010001;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  function automatic dec_t decode_grp(input logic [GRP_W-1:0] g);
    dec_t r;
    r.ok = 1'b1;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default: begin
        r.ok  = 1'b0;
        r.nib = 4'h0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fx_rx_line.sv
// Three-level symbol -> transition bit -> plain bit (R1)
module fx_rx_line (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  output logic       nrz_o
);

  logic [1:0] lvl_q, lvl_d;
  logic       chg_q, chg_d;
  logic       chg2_q;

  always_comb begin
    lvl_d = (sym_i == 2'b10) ? 2'b00 : sym_i;
    chg_d = (lvl_d != lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 2'b00;
      chg_q  <= 1'b0;
      chg2_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      chg_q  <= chg_d;
      chg2_q <= chg_q;
    end
  end

  assign nrz_o = chg_q ^ chg2_q;

endmodule

// File: rtl/fx_rx_descram.sv
// Key regeneration, idle-based lock and loss of lock (R2, R3, R4)
module fx_rx_descram #(
  parameter int LFSR_W   = 11,
  parameter int TAP_HI   = 10,
  parameter int TAP_LO   = 8,
  parameter int LOCK_RUN = 60,
  parameter int LOSS_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_i,
  input  logic hunt_i,
  output logic plain_o,
  output logic locked_o
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int ZR_W  = $clog2(LOSS_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [ZR_W-1:0]  ZR_LAST  = ZR_W'(LOSS_RUN - 1);

  logic [LFSR_W-1:0] key_q, key_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [ZR_W-1:0]   zr_q, zr_d;
  logic              lk_q, lk_d;
  logic              key_bit, plain;

  always_comb begin
    key_bit = key_q[TAP_HI] ^ key_q[TAP_LO];
    plain   = nrz_i ^ key_bit;
    key_d   = lk_q ? {key_q[LFSR_W-2:0], key_bit} : {key_q[LFSR_W-2:0], ~nrz_i};
    run_d   = run_q;
    zr_d    = zr_q;
    lk_d    = lk_q;
    if (!lk_q) begin
      zr_d = '0;
      if (plain) begin
        if (run_q == RUN_LAST) begin
          lk_d  = 1'b1;
          run_d = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end else begin
      run_d = '0;
      if (hunt_i && !plain) begin
        if (zr_q == ZR_LAST) begin
          lk_d = 1'b0;
          zr_d = '0;
        end else begin
          zr_d = zr_q + 1'b1;
        end
      end else begin
        zr_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      run_q <= '0;
      zr_q  <= '0;
      lk_q  <= 1'b0;
    end else begin
      key_q <= key_d;
      run_q <= run_d;
      zr_q  <= zr_d;
      lk_q  <= lk_d;
    end
  end

  assign plain_o  = plain;
  assign locked_o = lk_q;

endmodule

// File: rtl/fx_rx_frame.sv
// Group alignment, decoding and frame control (R5..R9)
module fx_rx_frame
  import fx_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             locked_i,
  output logic             hunt_o,
  output logic             stb_o,
  output logic             dv_o,
  output logic             er_o,
  output logic [NIB_W-1:0] nib_o
);

  localparam int PH_W = $clog2(GRP_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

  frame_st_e        st_q, st_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             stb_q, stb_d, dv_q, dv_d, er_q, er_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic [GRP_W-1:0] grp;
  logic             grp_done;
  dec_t             dec;

  always_comb begin
    win_d    = {win_q[WIN_W-2:0], bit_i};
    grp      = win_d[GRP_W-1:0];
    dec      = decode_grp(grp);
    grp_done = (ph_q == PH_LAST);
    st_d     = st_q;
    ph_d     = ph_q;
    stb_d    = 1'b0;
    er_d     = 1'b0;
    nib_d    = nib_q;
    dv_d     = (st_q == ST_DATA) ? dv_q : 1'b0;
    if (!locked_i) begin
      st_d = ST_HUNT;
      ph_d = '0;
      dv_d = 1'b0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (win_d == START_PAT) begin
            st_d = ST_DATA;
            ph_d = '0;
          end
        end
        ST_DATA: begin
          if (grp_done) begin
            ph_d = '0;
            if (grp == GRP_END1) begin
              dv_d = 1'b0;
              st_d = ST_TAIL;
            end else if (grp == GRP_IDLE) begin
              stb_d = 1'b1;
              er_d  = 1'b1;
              dv_d  = 1'b1;
              nib_d = '0;
              st_d  = ST_HUNT;
            end else begin
              stb_d = 1'b1;
              dv_d  = 1'b1;
              er_d  = !dec.ok;
              nib_d = dec.nib;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (grp_done) begin
            ph_d = '0;
            st_d = ST_HUNT;
            if (grp != GRP_END2) begin
              stb_d = 1'b1;
              er_d  = 1'b1;
              nib_d = '0;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      win_q <= '0;
      ph_q  <= '0;
      stb_q <= 1'b0;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      nib_q <= '0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      ph_q  <= ph_d;
      stb_q <= stb_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      nib_q <= nib_d;
    end
  end

  assign hunt_o = (st_q == ST_HUNT);
  assign stb_o  = stb_q;
  assign dv_o   = dv_q;
  assign er_o   = er_q;
  assign nib_o  = nib_q;

endmodule

// File: rtl/fx_rx_decoder.sv
module fx_rx_decoder #(
  parameter int LFSR_W   = 11,
  parameter int TAP_HI   = 10,
  parameter int TAP_LO   = 8,
  parameter int LOCK_RUN = 60,
  parameter int LOSS_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  output logic       locked_o,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic       nib_stb_o,
  output logic [3:0] nib_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       nrz, plain, hunt, locked;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fx_rx_line u_line (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sym_i (sym_i),
    .nrz_o (nrz)
  );

  fx_rx_descram #(
    .LFSR_W   (LFSR_W),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO),
    .LOCK_RUN (LOCK_RUN),
    .LOSS_RUN (LOSS_RUN)
  ) u_descram (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .nrz_i    (nrz),
    .hunt_i   (hunt),
    .plain_o  (plain),
    .locked_o (locked)
  );

  fx_rx_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_i    (plain),
    .locked_i (locked),
    .hunt_o   (hunt),
    .stb_o    (nib_stb_o),
    .dv_o     (rx_dv_o),
    .er_o     (rx_er_o),
    .nib_o    (nib_o)
  );

  assign locked_o = locked;

endmodule

// File: rtl/fx_rx_decoder_chk.sv
module fx_rx_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic locked,
  input logic stb,
  input logic dv,
  input logic er
);

  logic [2:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= 3'd7;
    else if (stb)      gap_q <= 3'd0;
    else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  assert_stb_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> locked);

  assert_dv_rise_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> stb);

  assert_dv_fall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv) |-> !stb);

  assert_er_with_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    er |-> stb);

  assert_stb_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (gap_q >= 3'd4));

  assert_lock_drop_hunt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !$past(dv));

endmodule

bind fx_rx_decoder fx_rx_decoder_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .locked (locked_o),
  .stb    (nib_stb_o),
  .dv     (rx_dv_o),
  .er     (rx_er_o)
);

// File: tb/fx_rx_decoder_bench.sv
module fx_rx_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       locked_o, rx_dv_o, rx_er_o, nib_stb_o;
  logic [3:0] nib_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fx_rx_decoder u_fx_rx_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_i     (sym),
    .locked_o  (locked_o),
    .rx_dv_o   (rx_dv_o),
    .rx_er_o   (rx_er_o),
    .nib_stb_o (nib_stb_o),
    .nib_o     (nib_o)
  );

  // transmit model
  logic [10:0] tx_key = 11'h5A3;
  logic        tx_t = 1'b0;
  int          tx_idx = 0;
  bit          alt_zero = 1'b0;

  function automatic logic [1:0] lvl_code(input int idx, input bit alt);
    case (idx)
      1:       return 2'b01;
      3:       return 2'b11;
      default: return alt ? 2'b10 : 2'b00;
    endcase
  endfunction

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16];
    t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
          5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic send_bit(input logic b);
    logic k, c;
    k = tx_key[10] ^ tx_key[8];
    tx_key = {tx_key[9:0], k};
    c = b ^ k;
    tx_t = tx_t ^ c;
    if (tx_t) tx_idx = (tx_idx + 1) % 4;
    @(negedge clk);
    sym <= lvl_code(tx_idx, alt_zero);
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // event capture
  logic [5:0] got [0:127];
  logic [5:0] expv [0:127];
  int ngot = 0;
  int nexp = 0;

  always @(negedge clk) begin
    if (rst_n && nib_stb_o) begin
      if (ngot < 128) got[ngot] = {rx_dv_o, rx_er_o, nib_o};
      ngot = ngot + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, expd);
    end
  endtask

  task automatic clear_ev();
    ngot = 0;
    nexp = 0;
  endtask

  task automatic push(input logic dv, input logic er, input logic [3:0] n);
    expv[nexp] = {dv, er, n};
    nexp++;
  endtask

  task automatic compare(input string req);
    check(ngot == nexp, req, "strobe count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(got[i] == expv[i], req, "event {dv,er,nib}", got[i], expv[i]);
  endtask

  task automatic send_start();
    send_grp(5'b11000);
    send_grp(5'b10001);
  endtask

  task automatic send_end();
    send_grp(5'b01101);
    send_grp(5'b00111);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check(!locked_o && !rx_dv_o && !rx_er_o && !nib_stb_o, "R11", "outputs in reset",
          {locked_o, rx_dv_o, rx_er_o, nib_stb_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!locked_o && !rx_dv_o && !nib_stb_o, "R11", "outputs after release",
          {locked_o, rx_dv_o, nib_stb_o}, 0);

    // R3: no lock before 60 matching bits, lock after
    send_idle(45);
    check(locked_o == 1'b0, "R3", "locked early", locked_o, 0);
    send_idle(75);
    check(locked_o == 1'b1, "R3", "locked after idle run", locked_o, 1);

    // R6 R2 R1: all sixteen nibbles
    clear_ev();
    send_start();
    for (int n = 0; n < 16; n++) begin
      send_grp(enc(4'(n)));
      push(1'b1, 1'b0, 4'(n));
    end
    send_end();
    send_idle(30);
    compare("R6");
    check(rx_dv_o == 1'b0, "R7", "dv after end pair", rx_dv_o, 0);
    check(locked_o == 1'b1, "R2", "lock kept over frame", locked_o, 1);

    // R1: alternate zero-level code, second pattern
    alt_zero = 1'b1;
    clear_ev();
    send_idle(20);
    send_start();
    for (int n = 0; n < 10; n++) begin
      send_grp(enc(4'((n * 7 + 3) % 16)));
      push(1'b1, 1'b0, 4'((n * 7 + 3) % 16));
    end
    send_end();
    send_idle(30);
    compare("R1");
    alt_zero = 1'b0;

    // R8: sweep of all group values inside one frame
    clear_ev();
    send_start();
    for (int g = 0; g < 32; g++) begin
      if (g != 5'b11111 && g != 5'b01101) begin
        logic hit;
        logic [3:0] v;
        hit = 1'b0;
        v = 4'h0;
        for (int n = 0; n < 16; n++)
          if (enc(4'(n)) == 5'(g)) begin
            hit = 1'b1;
            v = 4'(n);
          end
        send_grp(5'(g));
        push(1'b1, !hit, hit ? v : 4'h0);
      end
    end
    send_end();
    send_idle(30);
    compare("R8");

    // R7: end group followed by a wrong group
    clear_ev();
    send_start();
    send_grp(enc(4'h5));
    push(1'b1, 1'b0, 4'h5);
    send_grp(5'b01101);
    send_grp(5'b11111);
    push(1'b0, 1'b1, 4'h0);
    send_idle(30);
    compare("R7");

    // R9: idle inside a frame
    clear_ev();
    send_start();
    send_grp(enc(4'h7));
    push(1'b1, 1'b0, 4'h7);
    send_grp(5'b11111);
    push(1'b1, 1'b1, 4'h0);
    send_idle(10);
    compare("R9");
    check(rx_dv_o == 1'b0, "R9", "dv after idle in frame", rx_dv_o, 0);
    send_idle(20);

    // R4: zero run outside a frame drops lock
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    send_idle(4);
    check(locked_o == 1'b0, "R4", "lock after zero run", locked_o, 0);

    // R5: frame while unlocked is ignored
    clear_ev();
    send_idle(20);
    send_start();
    for (int n = 0; n < 4; n++) send_grp(enc(4'(n + 9)));
    send_end();
    send_idle(10);
    compare("R5");
    check(locked_o == 1'b0, "R5", "still unlocked", locked_o, 0);

    // R3: regain lock, then decode again
    send_idle(100);
    check(locked_o == 1'b1, "R3", "relocked", locked_o, 1);
    clear_ev();
    send_start();
    for (int n = 15; n >= 0; n -= 3) begin
      send_grp(enc(4'(n)));
      push(1'b1, 1'b0, 4'(n));
    end
    send_end();
    send_idle(30);
    compare("R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule